// File: doc/BRIEF.md
# Row-Buffered DRAM Array Controller

This block is a synchronous model of a small DRAM array together with the sequencer that drives it. The array is a square grid of supercells, each one word wide, and it is reached through a narrow shared address bus. That bus carries a row index first and a column index second. The row step copies a whole grid row into an internal row buffer. The column step then either returns one supercell from that buffer or overwrites one supercell in it. A buffered row goes back into the grid when the row is closed.

The CPU side sees a flat supercell address and a single-request handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read ends with a one-cycle `rd_valid` pulse, and `rd_data` holds the word during that cycle. The sequencer keeps the last opened row open. A request to that row needs only the column step. A request to any other row first writes the open row back and then opens the new one.

A free-running interval timer requests a refresh sweep over all rows. The sweep starts only between requests. It closes any open row, and `req_ready` stays low for the whole sweep. Each step (row open, column access, write-back, per-row refresh) takes a fixed number of cycles, and each of these counts is a parameter.

Top module: `dram_ctl_top`

## Requirements
- R1: After reset `req_ready` is 1, `rd_valid` is 0, no row is open and every supercell reads as 0.
- R2: The flat address puts the row in bits [2*AW-1:AW] and the column in bits [AW-1:0], with AW = log2(ROWS) (default: row = bits [3:2], column = bits [1:0]). A read returns the word most recently written to the same address, and each cell is independent of the others.
- R3: When no row is open, a request takes T_RAS+T_COL cycles (default 5) from its acceptance edge to the edge that completes it.
- R4: `rd_valid` goes high for exactly one cycle, at the completion edge of a read only. A write or an idle cycle never raises it.
- R5: When the requested row is already open, the row step is skipped and the request takes T_COL cycles (default 2).
- R6: When a different row is open, that row is written back and the new row is opened, so the request takes T_WB+T_RAS+T_COL cycles (default 7).
- R7: A word written into the row buffer reaches the grid when its row is closed, and it survives later row changes and refresh sweeps.
- R8: A refresh sweep holds `req_ready` low for 1+ROWS*T_REF cycles (default 9), or for T_WB more cycles (default 11) when a row was open. The sweep leaves no row open.
- R9: Refresh sweeps begin every REFRESH_PERIOD cycles while the block is idle. A sweep never interrupts a request, and the gap between two sweep starts never exceeds REFRESH_PERIOD plus the longest request.
- R10: `req_ready` is low while a request is in progress and while a refresh is pending or running. A request is taken only on an edge where `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*AW | Flat supercell address (row high, column low) |
| req_wdata | input | WORD_W | Write word |
| req_ready | output | 1 | Request is taken on this edge if `req_valid` is high |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | WORD_W | Read word, valid while `rd_valid` is high |

## Verification
The assertions assume that requests arrive only through the ready/valid handshake. They also assume that REFRESH_PERIOD is much longer than a refresh sweep plus the longest request, so a new refresh request can never overlap one that is still pending. The bench keeps within this by sampling `req_ready` at the falling edge before it lets a request count as taken, and by using an interval of 96 cycles against a worst case of about 20. Stimulus covers row hits, row misses with and without an open row, and long idle stretches. The bench follows the open row itself, and it marks the row closed whenever it sees `req_ready` low outside a request.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

   // Sequencer steps; each lasts a parameterised number of cycles.
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CLOSE   = 3'd1,   // write row buffer back to the grid
      ST_OPEN    = 3'd2,   // row strobe: grid row into row buffer
      ST_COL     = 3'd3,   // column strobe: one supercell moves
      ST_REFRESH = 3'd4    // sweep over every row
   } step_e;

   function automatic int step_cnt_w(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return (m < 2) ? 1 : $clog2(m);
   endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int PERIOD = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic due
);
   localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
         due    <= 1'b0;
      end else begin
         if (ack) due <= 1'b0;
         if (tick_q == LAST) begin
            tick_q <= '0;
            due    <= 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   parameter int WORD_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(ROWS)-1:0]  abus,
   input  logic                     ras_stb,
   input  logic                     cas_wr_stb,
   input  logic                     wb_stb,
   input  logic [WORD_W-1:0]        wdata,
   output logic [WORD_W-1:0]        dq
);
   localparam int AW = $clog2(ROWS);

   typedef logic [COLS-1:0][WORD_W-1:0] line_t;

   line_t         rowbuf_q;
   logic [AW-1:0] lat_row_q;
   line_t         grid_rd [ROWS];

   // Row buffer and latched row index.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rowbuf_q  <= '0;
         lat_row_q <= '0;
      end else if (ras_stb) begin
         rowbuf_q  <= grid_rd[abus];
         lat_row_q <= abus;
      end else if (cas_wr_stb) begin
         rowbuf_q[abus] <= wdata;
      end
   end

   // One storage line per grid row; written only by a write-back.
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      line_t cells_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cells_q <= '0;
         else if (wb_stb && (lat_row_q == AW'(r)))
            cells_q <= rowbuf_q;
      end
      assign grid_rd[r] = cells_q;
   end

   assign dq = rowbuf_q[abus];
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dram_ctl_pkg::*;
#(
   parameter int ROWS   = 4,
   parameter int WORD_W = 8,
   parameter int T_RAS  = 3,
   parameter int T_COL  = 2,
   parameter int T_WB   = 2,
   parameter int T_REF  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [2*$clog2(ROWS)-1:0] req_addr,
   input  logic [WORD_W-1:0]       req_wdata,
   output logic                    req_ready,
   output logic                    rd_valid,
   output logic [WORD_W-1:0]       rd_data,
   input  logic                    ref_due,
   output logic                    ref_ack,
   output logic [$clog2(ROWS)-1:0] abus,
   output logic                    ras_stb,
   output logic                    cas_stb,
   output logic                    cas_wr_stb,
   output logic                    wb_stb,
   output logic [WORD_W-1:0]       wdata,
   input  logic [WORD_W-1:0]       dq,
   output logic                    row_open,
   output logic                    in_refresh
);
   localparam int AW = $clog2(ROWS);
   localparam int CW = step_cnt_w(T_RAS, T_COL, T_WB, T_REF);
   localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
   localparam logic [CW-1:0] LD_COL = CW'(T_COL - 1);
   localparam logic [CW-1:0] LD_WB  = CW'(T_WB - 1);
   localparam logic [CW-1:0] LD_REF = CW'(T_REF - 1);
   localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

   step_e               state_q;
   logic [CW-1:0]       cnt_q;
   logic                op_write_q;
   logic [AW-1:0]       op_row_q, op_col_q, open_row_q, ref_row_q;
   logic [WORD_W-1:0]   op_wdata_q;
   logic                open_q, ref_pend_q;
   logic                step_end, accept, hit;

   assign step_end   = (cnt_q == '0);
   assign req_ready  = (state_q == ST_IDLE) && !ref_due;
   assign ref_ack    = (state_q == ST_IDLE) && ref_due;
   assign accept     = req_valid && req_ready;
   assign hit        = open_q && (open_row_q == req_addr[2*AW-1:AW]);

   assign ras_stb    = (state_q == ST_OPEN)  && step_end;
   assign cas_stb    = (state_q == ST_COL)   && step_end;
   assign cas_wr_stb = cas_stb && op_write_q;
   assign wb_stb     = (state_q == ST_CLOSE) && step_end;
   assign wdata      = op_wdata_q;
   assign row_open   = open_q;
   assign in_refresh = (state_q == ST_REFRESH);

   // Shared narrow address bus: row, then column.
   always_comb begin
      unique case (state_q)
         ST_COL:     abus = op_col_q;
         ST_CLOSE:   abus = open_row_q;
         ST_REFRESH: abus = ref_row_q;
         default:    abus = op_row_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         op_write_q <= 1'b0;
         op_row_q   <= '0;
         op_col_q   <= '0;
         op_wdata_q <= '0;
         open_q     <= 1'b0;
         open_row_q <= '0;
         ref_row_q  <= '0;
         ref_pend_q <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (ref_due) begin
                  ref_pend_q <= 1'b1;
                  ref_row_q  <= '0;
                  if (open_q) begin
                     state_q <= ST_CLOSE;
                     cnt_q   <= LD_WB;
                  end else begin
                     state_q <= ST_REFRESH;
                     cnt_q   <= LD_REF;
                  end
               end else if (accept) begin
                  op_write_q <= req_write;
                  op_row_q   <= req_addr[2*AW-1:AW];
                  op_col_q   <= req_addr[AW-1:0];
                  op_wdata_q <= req_wdata;
                  if (hit) begin
                     state_q <= ST_COL;
                     cnt_q   <= LD_COL;
                  end else if (open_q) begin
                     state_q <= ST_CLOSE;
                     cnt_q   <= LD_WB;
                  end else begin
                     state_q <= ST_OPEN;
                     cnt_q   <= LD_RAS;
                  end
               end
            end
            ST_CLOSE: begin
               if (step_end) begin
                  open_q <= 1'b0;
                  if (ref_pend_q) begin
                     state_q <= ST_REFRESH;
                     cnt_q   <= LD_REF;
                  end else begin
                     state_q <= ST_OPEN;
                     cnt_q   <= LD_RAS;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_OPEN: begin
               if (step_end) begin
                  open_q     <= 1'b1;
                  open_row_q <= op_row_q;
                  state_q    <= ST_COL;
                  cnt_q      <= LD_COL;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_COL: begin
               if (step_end) begin
                  if (!op_write_q) begin
                     rd_valid <= 1'b1;
                     rd_data  <= dq;
                  end
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_REFRESH: begin
               if (step_end) begin
                  if (ref_row_q == LAST_ROW) begin
                     ref_pend_q <= 1'b0;
                     state_q    <= ST_IDLE;
                  end else begin
                     ref_row_q <= ref_row_q + 1'b1;
                     cnt_q     <= LD_REF;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dram_ctl_top.sv
module dram_ctl_top #(
   parameter int ROWS           = 4,
   parameter int COLS           = 4,
   parameter int WORD_W         = 8,
   parameter int T_RAS          = 3,
   parameter int T_COL          = 2,
   parameter int T_WB           = 2,
   parameter int T_REF          = 2,
   parameter int REFRESH_PERIOD = 256
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [2*$clog2(ROWS)-1:0] req_addr,
   input  logic [WORD_W-1:0]         req_wdata,
   output logic                      req_ready,
   output logic                      rd_valid,
   output logic [WORD_W-1:0]         rd_data
);
   localparam int AW       = $clog2(ROWS);
   localparam int LONGEST  = T_WB + T_RAS + T_COL;
   localparam int SWEEP    = T_WB + ROWS * T_REF + 1;

   // Elaboration-time parameter checks.
   if (ROWS != COLS) begin : g_bad_shape
      $error("grid must be square");
   end
   if ((ROWS < 2) || ((1 << AW) != ROWS)) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if ((T_RAS < 1) || (T_COL < 1) || (T_WB < 1) || (T_REF < 1)) begin : g_bad_steps
      $error("every step needs at least one cycle");
   end
   if (REFRESH_PERIOD <= SWEEP + LONGEST + 1) begin : g_bad_period
      $error("refresh interval too short");
   end

   logic                ref_due, ref_ack;
   logic [AW-1:0]       abus;
   logic                ras_stb, cas_stb, cas_wr_stb, wb_stb;
   logic [WORD_W-1:0]   wdata, dq;
   logic                row_open, in_refresh;

   dram_refresh_timer #(.PERIOD(REFRESH_PERIOD)) timer_i (
      .clk (clk),
      .rst_n (rst_n),
      .ack (ref_ack),
      .due (ref_due)
   );

   dram_seq_ctrl #(
      .ROWS(ROWS), .WORD_W(WORD_W),
      .T_RAS(T_RAS), .T_COL(T_COL), .T_WB(T_WB), .T_REF(T_REF)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_ready  (req_ready),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .ref_due    (ref_due),
      .ref_ack    (ref_ack),
      .abus       (abus),
      .ras_stb    (ras_stb),
      .cas_stb    (cas_stb),
      .cas_wr_stb (cas_wr_stb),
      .wb_stb     (wb_stb),
      .wdata      (wdata),
      .dq         (dq),
      .row_open   (row_open),
      .in_refresh (in_refresh)
   );

   dram_cell_array #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) array_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .abus       (abus),
      .ras_stb    (ras_stb),
      .cas_wr_stb (cas_wr_stb),
      .wb_stb     (wb_stb),
      .wdata      (wdata),
      .dq         (dq)
   );
endmodule

// File: rtl/dram_ctl_chk.sv
module dram_ctl_chk #(
   parameter int LIMIT = 300
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rd_valid,
   input logic ref_due,
   input logic ref_ack,
   input logic ras_stb,
   input logic cas_stb,
   input logic wb_stb,
   input logic row_open,
   input logic in_refresh
);
   int unsigned gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gap_q <= 0;
      else if (ref_ack)
         gap_q <= 0;
      else if (gap_q < LIMIT + 8)
         gap_q <= gap_q + 1;
   end

   // R4: completion pulse lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R5: a row strobe happens only when no row is open
   a_r5_no_ras_when_open: assert property (@(posedge clk) disable iff (!rst_n)
      ras_stb |-> !row_open);

   // R3: a column strobe always targets an open row
   a_r3_cas_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
      cas_stb |-> row_open);

   // R6: a write-back closes the row
   a_r6_writeback_closes: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stb |=> !row_open);

   // R8: the sweep runs with no row open
   a_r8_sweep_closed: assert property (@(posedge clk) disable iff (!rst_n)
      in_refresh |-> !row_open);

   // R10: no request is taken while refresh is pending
   a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      ref_due |-> !req_ready);

   // R9: sweeps start within the interval plus one request
   a_r9_sweep_interval: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= LIMIT);
endmodule

bind dram_ctl_top dram_ctl_chk #(
   .LIMIT(REFRESH_PERIOD + T_WB + T_RAS + T_COL + 1)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .ref_due    (ref_due),
   .ref_ack    (ref_ack),
   .ras_stb    (ras_stb),
   .cas_stb    (cas_stb),
   .wb_stb     (wb_stb),
   .row_open   (row_open),
   .in_refresh (in_refresh)
);

// File: tb/dram_ctl_top_tb_top.sv
`timescale 1ns/1ps
module dram_ctl_top_tb_top;
   localparam int ROWS = 4;
   localparam int AW   = 2;
   localparam int W    = 8;
   localparam int TR   = 3;
   localparam int TC   = 2;
   localparam int TW   = 2;
   localparam int TF   = 2;
   localparam int P    = 96;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [2*AW-1:0] req_addr = '0;
   logic [W-1:0]  req_wdata = '0;
   logic          req_ready, rd_valid;
   logic [W-1:0]  rd_data;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   logic [W-1:0] model_mem [ROWS*ROWS];
   bit           model_open = 0;
   int           model_row  = 0;

   always #2 clk = ~clk;

   dram_ctl_top #(
      .ROWS(ROWS), .COLS(ROWS), .WORD_W(W),
      .T_RAS(TR), .T_COL(TC), .T_WB(TW), .T_REF(TF), .REFRESH_PERIOD(P)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // One request through the handshake; latency and data against the model.
   task automatic do_req(input bit wr, input int addr, input logic [W-1:0] data, input string tag);
      int row, lat;
      @(negedge clk);
      while (!req_ready) begin
         model_open = 0;
         @(negedge clk);
      end
      row = addr / ROWS;
      if (model_open && model_row == row) lat = TC;
      else if (model_open)                lat = TW + TR + TC;
      else                                lat = TR + TC;
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = (2*AW)'(addr);
      req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= lat; k++) begin
         @(negedge clk);
         if (k < lat) begin
            check(rd_valid == 1'b0, {tag, " R4 early pulse"}, int'(rd_valid), 0);
            check(req_ready == 1'b0, {tag, " R10 ready while busy"}, int'(req_ready), 0);
         end else begin
            check(rd_valid == !wr, {tag, " R3/R5/R6 completion cycle"}, int'(rd_valid), int'(!wr));
            if (!wr)
               check(rd_data == model_mem[addr], {tag, " R2 read data"}, int'(rd_data), int'(model_mem[addr]));
            if (!req_ready) model_open = 0;
            else            model_open = 1;
         end
      end
      if (wr) model_mem[addr] = data;
      if (req_ready) begin
         model_open = 1;
         model_row  = row;
      end
      @(negedge clk);
      check(rd_valid == 1'b0, {tag, " R4 pulse width"}, int'(rd_valid), 0);
      if (!req_ready) model_open = 0;
   endtask

   // Idle stretch: refresh sweeps measured at the ready output.
   task automatic idle_observe(input int n);
      bit prev, in_ep, open_at_fall, have_fall;
      int fall_i, len;
      prev = req_ready; in_ep = 0; have_fall = 0; fall_i = 0; len = 0; open_at_fall = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(rd_valid == 1'b0, "R4 no pulse while idle", int'(rd_valid), 0);
         if (prev && !req_ready) begin
            if (have_fall)
               check(i - fall_i == P, "R9 sweep spacing", i - fall_i, P);
            have_fall = 1; fall_i = i; in_ep = 1; len = 0;
            open_at_fall = model_open;
         end
         if (!req_ready) begin
            len++;
            model_open = 0;
         end else if (!prev && in_ep) begin
            check(len == 1 + ROWS*TF + (open_at_fall ? TW : 0), "R8 sweep length",
                  len, 1 + ROWS*TF + (open_at_fall ? TW : 0));
            in_ep = 0;
         end
         prev = req_ready;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < ROWS*ROWS; a++) model_mem[a] = '0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check(rd_valid == 1'b0, "R1 no pulse after reset", int'(rd_valid), 0);

      // R1 zero contents, R3 closed-row latency, R5 row hit
      do_req(0, 5, '0, "R1 r3_closed");
      do_req(0, 6, '0, "R5 hit");
      do_req(0, 9, '0, "R6 miss_open");

      // R2 fill every cell, row by row
      for (int a = 0; a < ROWS*ROWS; a++)
         do_req(1, a, W'(a*37 + 11), "R2 fill");
      // sequential, reversed and column-major reads
      for (int a = 0; a < ROWS*ROWS; a++) do_req(0, a, '0, "R2 seq");
      for (int a = ROWS*ROWS-1; a >= 0; a--) do_req(0, a, '0, "R2 rev");
      for (int c = 0; c < ROWS; c++)
         for (int r = 0; r < ROWS; r++) do_req(0, r*ROWS + c, '0, "R6 interleave");

      // R7 write-back on close
      do_req(1, 13, 8'hA5, "R7 write");
      do_req(1, 14, 8'h5A, "R7 write hit");
      do_req(0, 2,  '0,    "R7 other row");
      do_req(0, 13, '0,    "R7 readback");
      do_req(0, 14, '0,    "R7 readback hit");

      // R8/R9 sweeps over an idle stretch, with a row left open
      do_req(1, 7, 8'h3C, "R7 open before sweep");
      idle_observe(3*P + 20);
      // R8 sweep closed the row: closed-row latency; R7 data survived
      do_req(0, 7, '0, "R8 after sweep");
      for (int a = 0; a < ROWS*ROWS; a++) do_req(0, a, '0, "R7 survive");

      // Long mixed traffic through several sweeps (R9 boundary only)
      for (int i = 0; i < 120; i++) begin
         if (i % 3 == 0) do_req(1, (i*7) % 16, W'(i*13 + 1), "R9 mix wr");
         else            do_req(0, (i*5) % 16, '0, "R9 mix rd");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule